// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block keeps the program counter of a 32-bit RISC core whose jumps and branches have exactly one architectural delay slot. Each accepted instruction arrives as a decoded flow operation with its 26-bit target field, the value of its source register and the current condition flag. The unit presents the address of the next instruction to fetch. Control transfers take effect one instruction late: the delay-slot instruction at PC+4 always runs first, and the fetch address moves to the remembered target only once that slot instruction has been accepted.

Calls write the link register, register 11, with the address just past the delay slot. A control-transfer operation that arrives while the unit is waiting on a delay slot is flagged as an illegal-instruction fault for that cycle and leaves the pending target alone. Instruction fetch, the register file and exception handling sit outside; a system-call operation only picks a fixed vector address.

The instruction interface is valid/ready. `in_ready_o` is low during reset and high from the first clock edge after reset. An instruction counts as accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. Holding `in_valid_i` low stalls the unit without losing any state. The unit never applies back-pressure outside reset.

Top module: `npc_delay_unit`

## Requirements
- R1: While reset is asserted `fetch_pc_o` is 0 and `in_ready_o` is 0. Reset discards any pending delayed target, so the first instruction accepted after reset is never handled as a delay slot.
- R2: Operation codes on `op_i` are: 0 sequential, 1 absolute jump, 2 absolute jump-and-link, 3 register jump, 4 register jump-and-link, 5 relative branch-and-link, 6 branch-if-flag-clear, 7 branch-if-flag-set, 8 system call, 9 break. Codes 10 to 15 behave as sequential. A sequential instruction accepted outside a delay slot moves `fetch_pc_o` forward by 4.
- R3: An accepted control operation (codes 1 to 9) outside a delay slot moves `fetch_pc_o` to its own address plus 4, which is the delay slot.
- R4: Once the delay-slot instruction is accepted, `fetch_pc_o` becomes the target remembered from the control operation.
- R5: Codes 1 and 2 target the 26-bit field, sign-extended and shifted left by 2.
- R6: Codes 5, 6 and 7 target the branch's own address plus the sign-extended field shifted left by 2.
- R7: Code 7 is taken when `flag_i` is 1 and code 6 when `flag_i` is 0. A branch that is not taken continues at its own address plus 8.
- R8: Codes 3 and 4 target the `ra_i` value sampled in the cycle the jump is accepted. Later changes of `ra_i`, including during the delay slot, do not move the target.
- R9: In the cycle an accepted code 2, 4 or 5 sits outside a delay slot, `link_we_o` is 1, `link_idx_o` is 11 and `link_val_o` is the jump's address plus 8. `link_we_o` is 0 in every other cycle.
- R10: Code 8 redirects to address 0xC00 after its delay slot. Code 9 continues at its own address plus 8.
- R11: A control operation accepted in a delay slot raises `fault_o` in that cycle, writes no link, and leaves the pending target in place.
- R12: While no instruction is accepted, `fetch_pc_o` and any pending target hold. This includes a stall between a control operation and its delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction on the inputs is valid |
| in_ready_o | output | 1 | Unit can accept an instruction |
| op_i | input | 4 | Decoded flow operation code |
| disp_i | input | 26 | Displacement or absolute target field |
| ra_i | input | 32 | Source register value for register jumps |
| flag_i | input | 1 | Condition flag |
| fetch_pc_o | output | 32 | Address of the next instruction to fetch |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index (11) |
| link_val_o | output | 32 | Link value, delay-slot address plus 4 |
| fault_o | output | 1 | Control operation found in a delay slot |

## Verification
Straight sequential runs show plain PC stepping. Each jump and branch type is followed by a sequential delay slot, which separates the one-late redirect from an immediate one. Both flag values are driven on each conditional branch, with positive and negative displacements, so taken and not-taken paths are told apart, as are sign-extension errors. Register jumps change `ra_i` during the slot to show the target was captured early. Control operations placed in the slot, stalls in the middle of a slot, and a reset in the middle of a slot exercise the fault path, the hold path and the clearing of the pending target.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    OP_SEQ  = 4'd0,
    OP_J    = 4'd1,
    OP_JAL  = 4'd2,
    OP_JR   = 4'd3,
    OP_JALR = 4'd4,
    OP_BAL  = 4'd5,
    OP_BNF  = 4'd6,
    OP_BF   = 4'd7,
    OP_SYS  = 4'd8,
    OP_BRK  = 4'd9
  } flow_op_e;

  typedef enum logic [2:0] {
    TS_FALL = 3'd0,
    TS_ABS  = 3'd1,
    TS_REL  = 3'd2,
    TS_REG  = 3'd3,
    TS_VEC  = 3'd4
  } tgt_sel_e;

  typedef struct packed {
    logic     ctrl;
    logic     link;
    tgt_sel_e sel;
  } flow_dec_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       flag_i,
  output flow_dec_t  dec_o
);

  always_comb begin
    dec_o = '{ctrl: 1'b0, link: 1'b0, sel: TS_FALL};
    case (op_i)
      OP_J:    dec_o = '{ctrl: 1'b1, link: 1'b0, sel: TS_ABS};
      OP_JAL:  dec_o = '{ctrl: 1'b1, link: 1'b1, sel: TS_ABS};
      OP_JR:   dec_o = '{ctrl: 1'b1, link: 1'b0, sel: TS_REG};
      OP_JALR: dec_o = '{ctrl: 1'b1, link: 1'b1, sel: TS_REG};
      OP_BAL:  dec_o = '{ctrl: 1'b1, link: 1'b1, sel: TS_REL};
      OP_BNF:  dec_o = '{ctrl: 1'b1, link: 1'b0, sel: flag_i ? TS_FALL : TS_REL};
      OP_BF:   dec_o = '{ctrl: 1'b1, link: 1'b0, sel: flag_i ? TS_REL : TS_FALL};
      OP_SYS:  dec_o = '{ctrl: 1'b1, link: 1'b0, sel: TS_VEC};
      OP_BRK:  dec_o = '{ctrl: 1'b1, link: 1'b0, sel: TS_FALL};
      default: dec_o = '{ctrl: 1'b0, link: 1'b0, sel: TS_FALL};
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          DISP_W   = 26,
  parameter logic [31:0] TRAP_VEC = 32'h0000_0C00
) (
  input  tgt_sel_e          sel_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   ra_i,
  output logic [XLEN-1:0]   tgt_o
);

  localparam int SHIFT  = 2;
  localparam int EXT_W  = XLEN - DISP_W - SHIFT;
  localparam int STEP_2 = 8;

  logic [XLEN-1:0] offs;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offs = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, {SHIFT{1'b0}}};
    end else begin : g_trunc
      logic [DISP_W+SHIFT-1:0] wide;
      assign wide = {disp_i, {SHIFT{1'b0}}};
      assign offs = wide[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    case (sel_i)
      TS_ABS:  tgt_o = offs;
      TS_REL:  tgt_o = pc_i + offs;
      TS_REG:  tgt_o = ra_i;
      TS_VEC:  tgt_o = TRAP_VEC[XLEN-1:0];
      default: tgt_o = pc_i + XLEN'(STEP_2);
    endcase
  end

endmodule

// File: rtl/npc_delay_unit.sv
module npc_delay_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          DISP_W   = 26,
  parameter int          LINK_REG = 11,
  parameter int          IDX_W    = 5,
  parameter logic [31:0] TRAP_VEC = 32'h0000_0C00,
  parameter logic [31:0] RST_PC   = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [3:0]        op_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   ra_i,
  input  logic              flag_i,
  output logic [XLEN-1:0]   fetch_pc_o,
  output logic              link_we_o,
  output logic [IDX_W-1:0]  link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              fault_o
);

  localparam int INSN_BYTES = 4;
  localparam int LINK_OFFS  = 2 * INSN_BYTES;

  logic            ready_q;
  logic            slot_q;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pend_q;
  logic [XLEN-1:0] tgt;
  logic            accept;
  flow_dec_t       dec;

  npc_decode u_dec (
    .op_i   (op_i),
    .flag_i (flag_i),
    .dec_o  (dec)
  );

  npc_target #(
    .XLEN     (XLEN),
    .DISP_W   (DISP_W),
    .TRAP_VEC (TRAP_VEC)
  ) u_tgt (
    .sel_i  (dec.sel),
    .pc_i   (pc_q),
    .disp_i (disp_i),
    .ra_i   (ra_i),
    .tgt_o  (tgt)
  );

  assign accept = in_valid_i & ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      slot_q  <= 1'b0;
      pc_q    <= RST_PC[XLEN-1:0];
      pend_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      if (accept) begin
        if (slot_q) begin
          pc_q   <= pend_q;
          slot_q <= 1'b0;
        end else begin
          pc_q <= pc_q + XLEN'(INSN_BYTES);
          if (dec.ctrl) begin
            slot_q <= 1'b1;
            pend_q <= tgt;
          end
        end
      end
    end
  end

  assign in_ready_o = ready_q;
  assign fetch_pc_o = pc_q;
  assign link_we_o  = accept & ~slot_q & dec.link;
  assign link_idx_o = IDX_W'(LINK_REG);
  assign link_val_o = pc_q + XLEN'(LINK_OFFS);
  assign fault_o    = accept & slot_q & dec.ctrl;

endmodule

// File: rtl/npc_chk.sv
module npc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic            link_we_o,
  input logic            fault_o,
  input logic            slot_q,
  input logic [XLEN-1:0] pend_q
);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid_i && in_ready_o) |=> $stable(fetch_pc_o));

  // R3
  step_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !slot_q) |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(4));

  // R4
  slot_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && slot_q) |=> fetch_pc_o == $past(pend_q));

  // R9
  link_then_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |=> slot_q);

  // R11
  fault_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !link_we_o);

  // R11
  fault_keep_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fetch_pc_o == $past(pend_q));

endmodule

bind npc_delay_unit npc_chk #(.XLEN(XLEN)) u_npc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .fetch_pc_o (fetch_pc_o),
  .link_we_o  (link_we_o),
  .fault_o    (fault_o),
  .slot_q     (slot_q),
  .pend_q     (pend_q)
);

// File: tb/test_npc_delay_unit.sv
`timescale 1ns/1ps
module test_npc_delay_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [3:0]  op_i = 4'd0;
  logic [25:0] disp_i = '0;
  logic [31:0] ra_i = '0;
  logic        flag_i = 1'b0;
  logic [31:0] fetch_pc_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_val_o;
  logic        fault_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] m_pc = 32'd0;
  bit          m_slot = 0;
  logic [31:0] m_tgt = 32'd0;
  string       prev_tag = "R1";

  always #2.5 clk = ~clk;

  npc_delay_unit i_npc_delay_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .op_i       (op_i),
    .disp_i     (disp_i),
    .ra_i       (ra_i),
    .flag_i     (flag_i),
    .fetch_pc_o (fetch_pc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o),
    .fault_o    (fault_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_target(input logic [3:0] op, input logic [31:0] pc,
                                           input logic [25:0] f, input logic [31:0] ra, input bit fl);
    logic [31:0] sx;
    sx = {{4{f[25]}}, f, 2'b00};
    case (op)
      4'd1, 4'd2: return sx;
      4'd3, 4'd4: return ra;
      4'd5:       return pc + sx;
      4'd6:       return fl ? pc + 32'd8 : pc + sx;
      4'd7:       return fl ? pc + sx : pc + 32'd8;
      4'd8:       return 32'h0000_0C00;
      default:    return pc + 32'd8;
    endcase
  endfunction

  task automatic step(input string tag, input bit v, input logic [3:0] op,
                      input logic [25:0] f, input logic [31:0] ra, input bit fl);
    bit ctrl;
    bit exp_link;
    bit exp_fault;
    @(negedge clk);
    in_valid_i = v; op_i = op; disp_i = f; ra_i = ra; flag_i = fl;
    #1;
    ctrl      = (op >= 4'd1) && (op <= 4'd9);
    exp_link  = v && !m_slot && (op == 4'd2 || op == 4'd4 || op == 4'd5);
    exp_fault = v && m_slot && ctrl;
    chk(prev_tag, "fetch_pc", fetch_pc_o, m_pc);
    chk("R12", "in_ready", {31'd0, in_ready_o}, 32'd1);
    chk("R9", "link_we", {31'd0, link_we_o}, {31'd0, exp_link});
    if (exp_link) begin
      chk("R9", "link_val", link_val_o, m_pc + 32'd8);
      chk("R9", "link_idx", {27'd0, link_idx_o}, 32'd11);
    end
    chk("R11", "fault", {31'd0, fault_o}, {31'd0, exp_fault});
    if (v) begin
      if (m_slot) begin
        m_pc = m_tgt;
        m_slot = 0;
      end else begin
        if (ctrl) begin
          m_tgt = m_target(op, m_pc, f, ra, fl);
          m_slot = 1;
        end
        m_pc = m_pc + 32'd4;
      end
    end
    prev_tag = tag;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid_i = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "fetch_pc in reset", fetch_pc_o, 32'd0);
    chk("R1", "in_ready in reset", {31'd0, in_ready_o}, 32'd0);
    rst_n = 1'b1;
    m_pc = 32'd0; m_slot = 0; m_tgt = 32'd0;
    prev_tag = "R1";
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 sequential stepping and unused codes
    step("R2", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R2", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R2", 1, 4'hF, 26'd0, 32'd0, 0);
    // R12 stall
    step("R12", 0, 4'd1, 26'h40, 32'd0, 0);
    step("R12", 0, 4'd0, 26'd0, 32'd0, 0);
    // R5 absolute jump, R3 slot step, R4 redirect
    step("R3", 1, 4'd1, 26'h40, 32'd0, 0);
    step("R4", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R5", 1, 4'd2, 26'h3FF_FFF0, 32'd0, 0);
    step("R5", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R5", 1, 4'd1, 26'h80, 32'd0, 0);
    step("R5", 1, 4'd0, 26'd0, 32'd0, 0);
    // R7 branch on flag set, taken, with mid-slot stall (R12)
    step("R7", 1, 4'd7, 26'd4, 32'd0, 1);
    step("R12", 0, 4'd3, 26'd0, 32'hDEAD_0000, 0);
    step("R6", 1, 4'd0, 26'd0, 32'd0, 0);
    // R7 not taken paths and negative displacement
    step("R7", 1, 4'd7, 26'd4, 32'd0, 0);
    step("R7", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R6", 1, 4'd6, 26'h3FF_FFFE, 32'd0, 0);
    step("R6", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R7", 1, 4'd6, 26'h3FF_FFFE, 32'd0, 1);
    step("R7", 1, 4'd0, 26'd0, 32'd0, 0);
    // R6 branch-and-link
    step("R6", 1, 4'd5, 26'h10, 32'd0, 0);
    step("R6", 1, 4'd0, 26'd0, 32'd0, 0);
    // R8 register jumps, ra changes during slot
    step("R8", 1, 4'd3, 26'd0, 32'h0000_2000, 0);
    step("R8", 1, 4'd0, 26'd0, 32'h0000_5554, 0);
    step("R8", 1, 4'd4, 26'd0, 32'h0000_3000, 0);
    step("R8", 1, 4'd0, 26'd0, 32'h0000_1234, 0);
    // R10 system call and break
    step("R10", 1, 4'd8, 26'h55, 32'd0, 0);
    step("R10", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R10", 1, 4'd9, 26'h3, 32'd0, 0);
    step("R10", 1, 4'd0, 26'd0, 32'd0, 0);
    // R11 control ops in the delay slot
    step("R11", 1, 4'd1, 26'h100, 32'd0, 0);
    step("R11", 1, 4'd2, 26'h7, 32'd0, 0);
    step("R11", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R11", 1, 4'd3, 26'd0, 32'h0000_0800, 0);
    step("R11", 1, 4'd7, 26'h20, 32'd0, 1);
    step("R11", 1, 4'd0, 26'd0, 32'd0, 0);
    // R1 reset while a target is pending
    step("R1", 1, 4'd1, 26'h40, 32'd0, 0);
    do_reset();
    step("R1", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R1", 1, 4'd0, 26'd0, 32'd0, 0);
    step("R2", 0, 4'd0, 26'd0, 32'd0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule